// File: doc/BRIEF.md
# Memory-Mapped Write Master with Push FIFO

This block copies a programmed number of words from a small local FIFO onto a memory-mapped bus whose slave stalls the master through a waitrequest input. User logic first loads a start address, a byte count and an address-hold flag, then gives a one-cycle start pulse. It feeds the data words into the FIFO at any time with single-cycle push strobes.

The master drives one bus write for each word, using one word per write and no bursts. It keeps each write on the bus until the slave lets it through. When the hold flag is clear, the address advances by the word size after every accepted write. When the flag is set, every word goes to the start address, which is how a memory-mapped FIFO is filled. A completion flag stays high whenever the master is idle, and a new start pulse is taken only then.

The start address is expected to be word aligned. The byte count is expected to be a whole multiple of the word size.

Top module: `mm_write_master`

## Requirements
- R1: After reset `done` is 1, `bus_write` is 0 and `fifo_full` is 0.
- R2: A `go` pulse seen while `done` is 1 and `cfg_len` is nonzero takes effect at the next clock edge: from that edge `done` is 0 and the first write goes to `cfg_base`.
- R3: With `cfg_hold_addr` clear when `go` is accepted, write n (counting from 0) goes to `cfg_base + 4*n`, since the word size is 32 bits (4 bytes).
- R4: With `cfg_hold_addr` set when `go` is accepted, every write of the transfer goes to `cfg_base`.
- R5: `bus_write` is high only while the FIFO holds a word. The words are written in the order in which they were pushed.
- R6: A write is accepted on a clock edge where `bus_write` is 1 and `bus_waitreq` is 0. While `bus_waitreq` is 1, `bus_write`, `bus_addr` and `bus_wdata` keep their values into the next cycle.
- R7: A transfer makes exactly `cfg_len/4` accepted writes. `done` is 1 in the cycle that follows the edge on which the last write is accepted.
- R8: A `go` pulse that arrives while `done` is 0 has no effect on the running transfer's addresses, its data or its word count.
- R9: A `go` pulse with `cfg_len` equal to 0 leaves `done` at 1 and issues no bus write.
- R10: The FIFO holds 16 words. `fifo_full` is 1 exactly while 16 words are held, and a push made while `fifo_full` is 1 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Start address of the transfer |
| cfg_len | input | LW | Transfer length in bytes |
| cfg_hold_addr | input | 1 | Keep the address at the start address for the whole transfer |
| go | input | 1 | One-cycle start pulse |
| done | output | 1 | Master idle, ready for a start pulse |
| push | input | 1 | One-cycle FIFO push strobe |
| push_data | input | DW | Word to push |
| fifo_full | output | 1 | FIFO holds 16 words |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_write | output | 1 | Bus write request |
| bus_waitreq | input | 1 | Slave stall |

## Verification
`done` falls one edge after an accepted `go`. `bus_write` rises in the first cycle in which the FIFO is nonempty during a transfer. A stalled write must show the same address and data one cycle later. `done` rises one edge after the last accepted write.

The bench changes inputs, including a randomly toggled waitrequest, at the falling edge. It samples the outputs shortly after that edge, which is the combination the next rising edge will act on. An accept is therefore logged exactly when the design takes it, and the `done` check is made at the first sample that follows the last accept. Random transfers vary the length, the address mode and the push gaps. These are compared with addresses and data computed in the bench. Directed cases cover a zero length, a `go` that arrives mid-transfer and pushes into a full FIFO.

// File: rtl/mm_write_master.sv
module mm_write_master #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_hold_addr,
  input  logic          go,
  output logic          done,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          fifo_full,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_write,
  input  logic          bus_waitreq
);
  localparam int BYTES = DW / 8;
  localparam int PW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] level;
  logic          busy, hold_q;
  logic [LW-1:0] left;

  wire accept  = bus_write && !bus_waitreq;
  wire do_push = push && !fifo_full;
  wire start   = go && !busy && (cfg_len != '0);

  assign fifo_full = (level == CW'(DEPTH));
  assign bus_write = busy && (level != '0);
  assign bus_wdata = mem[rp];
  assign done      = !busy;

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(1);
      if (accept)  rp <= rp + PW'(1);
      case ({do_push, accept})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      hold_q   <= 1'b0;
      left     <= '0;
      bus_addr <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      hold_q   <= cfg_hold_addr;
      left     <= cfg_len;
      bus_addr <= cfg_base;
    end else if (accept) begin
      left <= left - LW'(BYTES);
      if (!hold_q) bus_addr <= bus_addr + AW'(BYTES);
      if (left <= LW'(BYTES)) busy <= 1'b0;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write && bus_waitreq |=> bus_write && $stable(bus_addr) && $stable(bus_wdata));

  // R4
  fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hold_q |=> bus_addr == $past(bus_addr));

  // R3
  step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hold_q |=> bus_addr == $past(bus_addr) + AW'(BYTES));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && done && cfg_len == '0 |=> done);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && done && cfg_len != '0 |=> !done && bus_addr == $past(cfg_base));
endmodule

// File: tb/mm_write_master_test.sv
module mm_write_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] cfg_base = 0, cfg_len = 0;
  logic        cfg_hold_addr = 0, go = 0, push = 0, bus_waitreq = 0;
  logic [31:0] push_data = 0;
  logic        done, fifo_full, bus_write;
  logic [31:0] bus_addr, bus_wdata;

  mm_write_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_len(cfg_len),
    .cfg_hold_addr(cfg_hold_addr), .go(go), .done(done), .push(push),
    .push_data(push_data), .fifo_full(fifo_full), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_write(bus_write), .bus_waitreq(bus_waitreq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int wait_pct = 0;
  int exp_n = 0;
  bit last_flag = 0, hold_pend = 0;
  logic [31:0] h_addr, h_data;
  logic [31:0] acc_addr[$], acc_data[$], pushed[$];

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(logic [31:0] base, bit fixed, int n);
    return fixed ? base : base + 32'(4 * n);
  endfunction

  // bus slave model and monitor
  always @(negedge clk) begin
    bus_waitreq = rst_n && (($urandom % 100) < wait_pct);
    #1;
    if (last_flag) begin
      check(done == 1'b1, "R7 done after last write", done, 1);
      last_flag = 0;
    end
    if (hold_pend)
      check(bus_write && bus_addr == h_addr && bus_wdata == h_data,
            "R6 held during stall", {bus_write, bus_addr}, {1'b1, h_addr});
    hold_pend = bus_write && bus_waitreq;
    h_addr = bus_addr;
    h_data = bus_wdata;
    if (bus_write && !bus_waitreq) begin
      acc_addr.push_back(bus_addr);
      acc_data.push_back(bus_wdata);
      if (acc_addr.size() == exp_n) last_flag = 1;
    end
  end

  task automatic pulse_go(logic [31:0] base, logic [31:0] len, bit fixed);
    @(negedge clk);
    cfg_base = base; cfg_len = len; cfg_hold_addr = fixed; go = 1;
    @(negedge clk);
    go = 0;
  endtask

  task automatic push_words(int n, int gap_pct);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      #2;
      if (!fifo_full && ($urandom % 100) >= gap_pct) begin
        push_data = $urandom;
        pushed.push_back(push_data);
        push = 1;
        k++;
      end else push = 0;
    end
    @(negedge clk);
    push = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(logic [31:0] base, bit fixed, int n, string tag);
    check(acc_addr.size() == n, {tag, " R7 write count"}, acc_addr.size(), n);
    for (int i = 0; i < n && i < acc_addr.size(); i++) begin
      check(acc_addr[i] == exp_addr(base, fixed, i),
            fixed ? {tag, " R4 address"} : {tag, " R3 address"}, acc_addr[i], exp_addr(base, fixed, i));
      check(acc_data[i] == pushed[i], {tag, " R5 data order"}, acc_data[i], pushed[i]);
    end
  endtask

  task automatic clear_logs(int n);
    acc_addr.delete(); acc_data.delete(); pushed.delete();
    exp_n = n;
  endtask

  task automatic run_xfer(int n, bit fixed, int gap);
    logic [31:0] base = $urandom & 32'hFFFF_FFFC;
    clear_logs(n);
    pulse_go(base, 32'(4 * n), fixed);
    check(done == 1'b0, "R2 done low after go", done, 0);
    push_words(n, gap);
    wait_done();
    check(done == 1'b1, "R7 done at end", done, 1);
    compare(base, fixed, n, "rand");
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #2;
    check(done == 1 && bus_write == 0 && fifo_full == 0, "R1 reset state",
          {done, bus_write, fifo_full}, 3'b100);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R9 zero length
    clear_logs(0);
    pulse_go(32'h100, 0, 0);
    check(done == 1'b1, "R9 done stays high", done, 1);
    push_words(2, 0);
    repeat (5) @(negedge clk);
    check(acc_addr.size() == 0, "R9 no bus writes", acc_addr.size(), 0);
    check(fifo_full == 1'b0, "R10 not full with two words", fifo_full, 0);
    // drain the two stray words with a 2-word transfer
    pulse_go(32'h200, 8, 0);
    exp_n = 2;
    wait_done();
    compare(32'h200, 0, 2, "drain");

    // R2 first address, stalls, incrementing
    wait_pct = 40;
    clear_logs(5);
    pushed.delete();
    pulse_go(32'h0000_1000, 20, 0);
    push_words(5, 30);
    wait_done();
    check(acc_addr.size() > 0 && acc_addr[0] == 32'h1000, "R2 first address",
          acc_addr.size() > 0 ? acc_addr[0] : 0, 32'h1000);
    compare(32'h1000, 0, 5, "dir");

    // R8 go while busy
    clear_logs(10);
    pulse_go(32'h0000_4000, 40, 0);
    push_words(2, 0);
    pulse_go(32'hDEAD_0000, 8, 1);
    check(done == 1'b0, "R8 still busy", done, 0);
    push_words(8, 0);
    wait_done();
    compare(32'h4000, 0, 10, "R8");

    // R10 full and dropped push
    wait_pct = 20;
    clear_logs(16);
    push_words(16, 0);
    #2;
    check(fifo_full == 1'b1, "R10 full at 16", fifo_full, 1);
    @(negedge clk);
    push_data = 32'hBAD0_BAD0; push = 1;
    @(negedge clk);
    push = 0;
    pulse_go(32'h0000_8000, 64, 1);
    wait_done();
    compare(32'h8000, 1, 16, "R10");
    repeat (4) @(negedge clk);
    check(acc_addr.size() == 16 && !bus_write, "R10 dropped push not written", acc_addr.size(), 16);
    check(fifo_full == 1'b0, "R10 not full after drain", fifo_full, 0);

    // constrained random transfers
    for (int t = 0; t < 40; t++) begin
      wait_pct = $urandom % 70;
      run_xfer(1 + ($urandom % 40), $urandom % 2, $urandom % 60);
    end
    finish_up();
  end
endmodule